// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of upcoming instruction bytes between a 16-bit code bus and an instruction decoder. While there is room for at least one more bus word and the execution side has no operand access waiting, it starts a look-ahead read at the next sequential code address. The returned word is split into bytes that are appended in address order. The decoder sees the oldest byte with a valid flag and consumes it with a pop. The store holds at most six bytes.

A control transfer is handled through the flush input. It empties the store, drops any read still outstanding, and loads a new 20-bit code address. An odd target address is fetched as a single byte on the high lane, so that every later read is word aligned.

The controller has two states. `ST_IDLE` means no code read is outstanding. `ST_FETCH` means a read request is being held on the bus. The transition `ST_IDLE -> ST_FETCH` (start) fires when flush is low, the operand request is low and the occupancy is at most four. The transition `ST_FETCH -> ST_IDLE` (done) fires on an acknowledge. The transition `ST_FETCH -> ST_IDLE` (abort) fires on a flush. In every other case the state stays as it is.

Top module: `prefetch_queue`

## Requirements
- R1: After reset, count is 0, byte_valid and fetch_req are low, and fetch_addr equals the reset code address (default 20'hFFFF0).
- R2: fetch_req rises only in the cycle after a clock edge at which count was at most 4 (two or more free slots); with count 5 or 6 no read starts.
- R3: No read starts after a clock edge at which oper_req was high; a read already under way is not affected.
- R4: When fetch_addr is even, an acknowledge appends fetch_data[7:0] and then fetch_data[15:8], and fetch_addr advances by 2.
- R5: When fetch_addr is odd, fetch_byte is high and an acknowledge appends only fetch_data[15:8], and fetch_addr advances by 1.
- R6: byte_data shows the oldest stored byte whenever byte_valid is high. A pop removes exactly that byte, so bytes leave in fetch order.
- R7: A pop while count is 0 is ignored: count stays 0 and no byte is lost from a later fill.
- R8: A flush empties the store, ignores any acknowledge in the same cycle, ends an outstanding read and loads flush_addr into fetch_addr.
- R9: count equals the number of stored bytes, never exceeds 6, and is correct when a pop and an append fall in the same cycle.
- R10: Once raised, fetch_req stays high with fetch_addr unchanged until an acknowledge or a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Control transfer: empty the store and redirect |
| flush_addr | input | 20 | New code address loaded on flush |
| oper_req | input | 1 | Execution side has an operand access waiting |
| fetch_req | output | 1 | Code read request, held until acknowledge |
| fetch_addr | output | 20 | Address of the next code read |
| fetch_byte | output | 1 | High when the read is a single high-lane byte (odd address) |
| fetch_ack | input | 1 | Read completes, fetch_data valid this cycle |
| fetch_data | input | 16 | Returned code word; odd address byte on bits 15:8 |
| byte_valid | output | 1 | byte_data holds a stored byte |
| byte_data | output | 8 | Oldest stored instruction byte |
| pop | input | 1 | Consume the byte on byte_data |
| count | output | 3 | Number of stored bytes, 0 to 6 |

## Verification
A free-running fill with no pops and no operand traffic shows whether the start rule stops at exactly four stored bytes. Popping from a full store then separates the thresholds of five and four. Holding oper_req high on an empty store tells the operand-priority rule apart from the occupancy rule. Flushes to odd and even targets, including the top of the address space, show whether single-byte alignment and address wrap are right. A long random mix of pops, operand requests, acknowledge latencies and flushes, with some flushes landing on an acknowledge, is compared byte for byte with a queue model on every clock. This exposes any ordering or counting slip when an append and a pop coincide.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } pfq_state_e;

endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
    import pfq_pkg::*;
#(
    parameter int DEPTH    = 6,
    parameter int MIN_FREE = 2,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             oper_req,
    input  logic [CNT_W-1:0] count,
    input  logic             fetch_ack,
    output logic             fetch_req,
    output logic             accept
);

    localparam logic [CNT_W-1:0] START_MAX = CNT_W'(DEPTH - MIN_FREE);

    pfq_state_e state, state_nx;
    logic       room_ok;

    assign room_ok = (count <= START_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!flush && !oper_req && room_ok) state_nx = ST_FETCH;
            end
            ST_FETCH: begin
                if (flush || fetch_ack) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        fetch_req = 1'b0;
        accept    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                fetch_req = 1'b0;
            end
            ST_FETCH: begin
                fetch_req = 1'b1;
                accept    = fetch_ack && !flush;
            end
            default: begin
                fetch_req = 1'b0;
            end
        endcase
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack && !flush) |=> fetch_req);

    // R3
    no_start_oper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> !$past(oper_req));

    // R2
    no_start_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> ($past(count) <= START_MAX));

endmodule

// File: rtl/pfq_ptr.sv
module pfq_ptr #(
    parameter int          ADDR_W     = 20,
    parameter logic [19:0] RESET_ADDR = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    input  logic              fetch_req,
    input  logic              fetch_ack,
    input  logic [15:0]       bus_word,
    output logic [ADDR_W-1:0] addr,
    output logic              odd,
    output logic [1:0]        push_n,
    output logic [7:0]        push_b0,
    output logic [7:0]        push_b1
);

    logic [ADDR_W-1:0] step;

    assign odd  = addr[0];
    assign step = odd ? ADDR_W'(1) : ADDR_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr <= ADDR_W'(RESET_ADDR);
        else if (load)    addr <= load_addr;
        else if (advance) addr <= addr + step;
    end

    always_comb begin
        push_n  = 2'd0;
        push_b0 = bus_word[7:0];
        push_b1 = bus_word[15:8];
        if (advance) begin
            if (odd) begin
                push_n  = 2'd1;
                push_b0 = bus_word[15:8];
            end else begin
                push_n  = 2'd2;
            end
        end
    end

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack && !load) |=> $stable(addr));

endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int DEPTH   = 6,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [1:0]       push_n,
    input  logic [7:0]       push_b0,
    input  logic [7:0]       push_b1,
    input  logic             pop,
    output logic             head_valid,
    output logic [7:0]       head_byte,
    output logic [CNT_W-1:0] count
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_ptr1;
    logic             pop_ok;
    logic [CNT_W-1:0] cnt_nx;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_valid = (count != '0);
    assign head_byte  = mem[rd_ptr];
    assign pop_ok     = pop && head_valid;
    assign wr_ptr1    = wrap_inc(wr_ptr);
    assign cnt_nx     = count - CNT_W'(pop_ok) + CNT_W'(push_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop_ok) rd_ptr <= wrap_inc(rd_ptr);
            if (push_n == 2'd1) wr_ptr <= wr_ptr1;
            else if (push_n == 2'd2) wr_ptr <= wrap_inc(wr_ptr1);
            count <= cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!clear) begin
            if (push_n != 2'd0) mem[wr_ptr]  <= push_b0;
            if (push_n == 2'd2) mem[wr_ptr1] <= push_b1;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !head_valid && push_n == 2'd0 && !clear) |=> (count == '0));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int          DEPTH      = 6,
    parameter int          MIN_FREE   = 2,
    parameter int          ADDR_W     = 20,
    parameter logic [19:0] RESET_ADDR = 20'hFFFF0,
    localparam int         CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              oper_req,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_byte,
    input  logic              fetch_ack,
    input  logic [15:0]       fetch_data,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    input  logic              pop,
    output logic [CNT_W-1:0]  count
);

    logic       accept;
    logic       odd;
    logic [1:0] push_n;
    logic [7:0] push_b0, push_b1;

    pfq_ctrl #(
        .DEPTH    (DEPTH),
        .MIN_FREE (MIN_FREE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .oper_req  (oper_req),
        .count     (count),
        .fetch_ack (fetch_ack),
        .fetch_req (fetch_req),
        .accept    (accept)
    );

    pfq_ptr #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (flush),
        .load_addr (flush_addr),
        .advance   (accept),
        .fetch_req (fetch_req),
        .fetch_ack (fetch_ack),
        .bus_word  (fetch_data),
        .addr      (fetch_addr),
        .odd       (odd),
        .push_n    (push_n),
        .push_b0   (push_b0),
        .push_b1   (push_b1)
    );

    pfq_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (flush),
        .push_n     (push_n),
        .push_b0    (push_b0),
        .push_b1    (push_b1),
        .pop        (pop),
        .head_valid (byte_valid),
        .head_byte  (byte_data),
        .count      (count)
    );

    assign fetch_byte = fetch_req && odd;

endmodule

// File: tb/tb_prefetch_queue.sv
module tb_prefetch_queue;

    localparam int          DEPTH = 6;
    localparam logic [19:0] RST_A = 20'hFFFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [19:0] flush_addr = '0;
    logic        oper_req = 1'b0;
    logic        fetch_req;
    logic [19:0] fetch_addr;
    logic        fetch_byte;
    logic        fetch_ack = 1'b0;
    logic [15:0] fetch_data = '0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        pop = 1'b0;
    logic [2:0]  count;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int waitc  = 0;

    logic [7:0]  mq[$];
    logic        m_busy = 1'b0;
    logic [19:0] m_addr = RST_A;

    always #4 clk = ~clk;

    prefetch_queue dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .oper_req(oper_req), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_byte(fetch_byte), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .byte_valid(byte_valid), .byte_data(byte_data), .pop(pop), .count(count)
    );

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h3};
    endfunction

    function automatic logic [15:0] bus_word(input logic [19:0] a);
        if (a[0]) return {mb(a), 8'hEE};
        return {mb(a + 20'd1), mb(a)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // behavioural queue model, updated on every rising edge
    always @(posedge clk) begin
        int c0;
        bit go;
        cycles++;
        if (!rst_n) begin
            mq.delete();
            m_busy = 1'b0;
            m_addr = RST_A;
        end else if (flush) begin
            mq.delete();
            m_busy = 1'b0;
            m_addr = flush_addr;
        end else begin
            c0 = mq.size();
            go = !m_busy && !oper_req && (c0 <= DEPTH - 2);
            if (pop && c0 > 0) void'(mq.pop_front());
            if (m_busy && fetch_ack) begin
                if (m_addr[0]) begin
                    mq.push_back(mb(m_addr));
                    m_addr = m_addr + 20'd1;
                end else begin
                    mq.push_back(mb(m_addr));
                    mq.push_back(mb(m_addr + 20'd1));
                    m_addr = m_addr + 20'd2;
                end
                m_busy = 1'b0;
            end else if (go) begin
                m_busy = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic compare();
        chk(fetch_req == m_busy, "R2/R3 fetch_req", fetch_req, m_busy);
        if (m_busy) begin
            chk(fetch_addr == m_addr, "R10 fetch_addr", fetch_addr, m_addr);
            chk(fetch_byte == m_addr[0], "R5 fetch_byte", fetch_byte, m_addr[0]);
        end
        chk(byte_valid == (mq.size() > 0), "R6 byte_valid", byte_valid, mq.size() > 0);
        if (mq.size() > 0)
            chk(byte_data == mq[0], "R6 byte_data", byte_data, mq[0]);
        chk(count == 3'(mq.size()), "R9 count", count, mq.size());
    endtask

    task automatic step(input bit f, input logic [19:0] fa, input bit o, input bit p,
                        input int lat, input bit force_ack);
        @(negedge clk);
        compare();
        flush = f;
        flush_addr = fa;
        oper_req = o;
        pop = p;
        if (fetch_req && (force_ack || waitc >= lat)) begin
            fetch_ack = 1'b1;
            fetch_data = bus_word(fetch_addr);
            waitc = 0;
        end else begin
            fetch_ack = 1'b0;
            fetch_data = 16'hDEAD;
            if (fetch_req) waitc++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state straight out of reset
        chk(count == 3'd0, "R1 count", count, 0);
        chk(!byte_valid, "R1 byte_valid", byte_valid, 0);
        chk(!fetch_req, "R1 fetch_req", fetch_req, 0);
        chk(fetch_addr == RST_A, "R1 fetch_addr", fetch_addr, RST_A);

        // R2 R4 R9: fill with no pops until the start rule stops
        repeat (20) step(0, '0, 0, 0, 1, 0);
        chk(count == 3'd6, "R9 full count", count, 6);
        chk(!fetch_req, "R2 no start when full", fetch_req, 0);
        chk(byte_data == mb(RST_A), "R4 low byte first", byte_data, mb(RST_A));
        step(0, '0, 0, 1, 1, 0);
        step(0, '0, 0, 0, 1, 0);
        chk(byte_data == mb(RST_A + 20'd1), "R4 high byte second", byte_data, mb(RST_A + 20'd1));
        step(0, '0, 0, 0, 1, 0);
        chk(!fetch_req, "R2 five stored no start", fetch_req, 0);
        step(0, '0, 0, 1, 1, 0);
        repeat (2) step(0, '0, 0, 0, 1, 0);
        chk(fetch_req, "R2 four stored starts", fetch_req, 1);
        repeat (6) step(0, '0, 0, 0, 1, 0);

        // R3: operand requests hold off prefetch on an empty store
        step(1, 20'h00100, 1, 0, 1, 0);
        repeat (10) step(0, '0, 1, 0, 1, 0);
        chk(!fetch_req, "R3 oper blocks start", fetch_req, 0);
        chk(count == 3'd0, "R3 nothing fetched", count, 0);

        // R7: pop while empty
        repeat (4) step(0, '0, 1, 1, 1, 0);
        chk(count == 3'd0, "R7 empty pop count", count, 0);
        repeat (6) step(0, '0, 0, 0, 1, 0);
        chk(byte_data == mb(20'h00100), "R7 first byte kept", byte_data, mb(20'h00100));

        // R5: odd target
        step(1, 20'h12345, 0, 0, 2, 0);
        step(0, '0, 0, 0, 2, 0);
        step(0, '0, 0, 0, 2, 0);
        chk(fetch_byte, "R5 odd single byte", fetch_byte, 1);
        repeat (12) step(0, '0, 0, 1, 2, 0);

        // R5 wrap at top of the address space
        step(1, 20'hFFFFF, 0, 0, 0, 0);
        repeat (15) step(0, '0, 0, 1, 0, 0);

        // R8: flush lands on an acknowledge
        step(1, 20'h00200, 0, 0, 100, 0);
        for (int i = 0; i < 10 && !fetch_req; i++) step(0, '0, 0, 0, 100, 0);
        step(1, 20'h00401, 0, 0, 0, 1);
        step(0, '0, 1, 0, 100, 0);
        chk(count == 3'd0, "R8 flush empties", count, 0);
        chk(!fetch_req, "R8 read aborted", fetch_req, 0);
        chk(fetch_addr == 20'h00401, "R8 new address", fetch_addr, 20'h00401);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit f;
            f = ($urandom_range(0, 99) < 2);
            step(f, 20'($urandom), ($urandom_range(0, 99) < 25),
                 ($urandom_range(0, 99) < 50), $urandom_range(0, 3),
                 ($urandom_range(0, 99) < 10));
        end
        step(0, '0, 0, 0, 0, 0);
        finish_run();
    end

endmodule